// File: doc/BRIEF.md
# Remappable Memory Map Decoder

This block turns every 16-bit bus address into a single region select for a small controller: internal RAM, the on-chip control register block, EEPROM, bootstrap ROM, the interrupt vector area, or the external bus. A two-pin boot mode is captured while reset is held. It decides which regions exist, whether an external bus is present, and whether the mapping register stays open for writes after start-up.

RAM and the register block can each be moved to any 4 KB page through an 8-bit mapping register. In the two normal modes, software gets one write to this register, and only within a fixed number of bus cycles after reset. After that the map is frozen. In the two special modes, the register accepts any number of writes at any time. When both windows land on the same page, the register block hides the RAM underneath it.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset the mapping register is 0x01. Its bits [7:4] hold the RAM page and bits [3:0] hold the register page. So RAM answers at 0x0000–0x03FF and the register block answers at 0x1000–0x105F.
- R2: A RAM page nibble P selects RAM for addresses P000–P3FF. A register page nibble Q selects the register block for Q000–Q05F.
- R3: In normal modes (mode_pins[1]=1), the mapping register takes a write (map_wr high on a clock edge) only while fewer than 64 bus_tick pulses have been seen since reset, and only once. A second write, or any write after the window, leaves the map unchanged.
- R4: In special modes (mode_pins[1]=0), every map_wr updates the mapping register, with no limit on when or how often.
- R5: Where the register window and the RAM window share a page, the first 96 bytes select the register block and the rest of the RAM range selects RAM.
- R6: mode_pins is latched on each clock edge while rst_n is low and is held after that. mode_pins[1] is pin B and mode_pins[0] is pin A. The outputs {boot_rom_en, special_mode, mode_a} are 000 for single-chip (10), 001 for expanded (11), 110 for bootstrap (00) and 011 for test (01).
- R7: Bootstrap ROM is selected for 0xBF00–0xBFFF, and only in bootstrap mode.
- R8: In expanded and test modes, with ee_en=1, EEPROM is selected for zE00–zFFF, where z is ee_page.
- R9: In single-chip and bootstrap modes, with ee_en=1, EEPROM is selected for 0xFE00–0xFFFF and ee_page is ignored.
- R10: In single-chip and bootstrap modes, 0xFFC0–0xFFFF selects the vector area whenever EEPROM does not claim it.
- R11: ext_bus is 1 in expanded and test modes and 0 otherwise. In expanded and test modes, every address that no other region claims selects external memory. In the other modes, the external select is never active.
- R12: region_sel bit positions are 0 register block, 1 RAM, 2 boot ROM, 3 EEPROM, 4 vector, 5 external. The priority follows that same order. At most one bit is set, and exactly one is set when ext_bus is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are sampled while low |
| mode_pins | input | 2 | Boot mode pins {B, A} |
| bus_tick | input | 1 | One pulse per bus cycle; counts the write window |
| addr | input | 16 | Address to decode |
| map_wr | input | 1 | Write strobe for the mapping register |
| map_wdata | input | 8 | Write data: [7:4] RAM page, [3:0] register page |
| ee_page | input | 4 | EEPROM page used when an external bus is present |
| ee_en | input | 1 | EEPROM enable |
| region_sel | output | 6 | One-hot region select |
| boot_rom_en | output | 1 | Latched boot ROM enable |
| special_mode | output | 1 | Latched special-mode flag |
| mode_a | output | 1 | Latched pin A level |
| ext_bus | output | 1 | External bus present |

## Verification
The decode is exercised with a fixed set of probe addresses placed at each region's first and last byte and one byte past each edge. This set is run in all four modes, with EEPROM both enabled and disabled, so it tells apart off-by-one range bounds, mode gating and priority errors. The mapping register is driven with writes at tick 63 and tick 64, with a second write inside the window, with gapped ticks, and with repeated late writes in special modes. These patterns separate counting bus ticks from counting clocks, and they separate the once-only rule from the time limit. One remap puts both windows on the same page to expose the overlap priority. Pins are changed after reset to show the latch holds.

// File: rtl/addr_map_pkg.sv
// Shared types for the memory map decoder: boot mode encoding,
// latched control bits and region select bit positions.
package addr_map_pkg;

    // Boot mode as {pin B, pin A}
    typedef enum logic [1:0] {
        MODE_BOOT   = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_EXP    = 2'b11
    } boot_mode_e;

    typedef struct packed {
        logic boot_rom_en;
        logic special;
        logic mode_a;
    } mode_ctl_t;

    localparam int N_REGION = 6;
    localparam int IDX_REG  = 0;
    localparam int IDX_RAM  = 1;
    localparam int IDX_BOOT = 2;
    localparam int IDX_EE   = 3;
    localparam int IDX_VEC  = 4;
    localparam int IDX_EXT  = 5;

    // Control bits implied by each boot mode
    function automatic mode_ctl_t decode_mode(boot_mode_e m);
        mode_ctl_t c;
        case (m)
            MODE_BOOT:   c = '{boot_rom_en: 1'b1, special: 1'b1, mode_a: 1'b0};
            MODE_TEST:   c = '{boot_rom_en: 1'b0, special: 1'b1, mode_a: 1'b1};
            MODE_SINGLE: c = '{boot_rom_en: 1'b0, special: 1'b0, mode_a: 1'b0};
            default:     c = '{boot_rom_en: 1'b0, special: 1'b0, mode_a: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addr_map_mode_latch.sv
// Captures the boot mode pins while reset is held and keeps them
// for the rest of the run. Assumes pins are stable during reset.
module addr_map_mode_latch
    import addr_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    output mode_ctl_t  ctl,
    output logic       has_ext
);
    boot_mode_e mode_q;

    // Sample pins on every edge inside reset, hold afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= boot_mode_e'(mode_pins);
        end
    end

    // Derive the control bits from the held mode
    always_comb begin
        ctl     = decode_mode(mode_q);
        has_ext = ctl.mode_a;
    end
endmodule

// File: rtl/addr_map_window_reg.sv
// Mapping register with a time-limited, write-once gate in normal
// modes and an unrestricted gate in special modes. The window counts
// bus_tick pulses, not clocks; the counter saturates at WIN_CYCLES.
module addr_map_window_reg #(
    parameter int          DATA_W     = 8,
    parameter int          WIN_CYCLES = 64,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              special,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] map_q
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] WIN_L = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] tick_cnt;
    logic             used_q;
    logic             wr_open;

    // Count bus cycles since reset, stop at the window length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (bus_tick && (tick_cnt != WIN_L)) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Decide whether a write lands this cycle
    always_comb begin
        wr_open = special || ((tick_cnt < WIN_L) && !used_q);
    end

    // Hold the map value and the once-only flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= RESET_VAL;
            used_q <= 1'b0;
        end else if (wr && wr_open) begin
            map_q  <= wdata;
            used_q <= 1'b1;
        end
    end
endmodule

// File: rtl/addr_map_region_decode.sv
// Combinational address decoder. Computes a raw hit per region, then
// keeps only the highest-priority hit (lowest index). Assumes
// RAM_BYTES, REG_BYTES and EE_BYTES fit inside one page.
module addr_map_region_decode
    import addr_map_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int PAGE_W        = 4,
    parameter int RAM_BYTES     = 1024,
    parameter int REG_BYTES     = 96,
    parameter int EE_BYTES      = 512,
    parameter int BOOT_BASE     = 'hBF00,
    parameter int BOOT_BYTES    = 256,
    parameter int VEC_BASE      = 'hFFC0,
    parameter int FIXED_EE_PAGE = 15
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_W-1:0]   ram_page,
    input  logic [PAGE_W-1:0]   reg_page,
    input  logic [PAGE_W-1:0]   ee_page,
    input  logic                ee_en,
    input  mode_ctl_t           ctl,
    input  logic                has_ext,
    output logic [N_REGION-1:0] sel
);
    localparam int OFF_W = ADDR_W - PAGE_W;
    localparam logic [OFF_W-1:0]  REG_LIM = OFF_W'(REG_BYTES);
    localparam logic [OFF_W-1:0]  RAM_LIM = OFF_W'(RAM_BYTES);
    localparam logic [OFF_W-1:0]  EE_LO   = OFF_W'((1 << OFF_W) - EE_BYTES);
    localparam logic [ADDR_W-1:0] BOOT_LO = ADDR_W'(BOOT_BASE);
    localparam logic [ADDR_W-1:0] BOOT_HI = ADDR_W'(BOOT_BASE + BOOT_BYTES - 1);
    localparam logic [ADDR_W-1:0] VEC_LO  = ADDR_W'(VEC_BASE);
    localparam logic [PAGE_W-1:0] EE_FIX  = PAGE_W'(FIXED_EE_PAGE);

    logic [PAGE_W-1:0]   page;
    logic [OFF_W-1:0]    off;
    logic [PAGE_W-1:0]   ee_sel_page;
    logic [N_REGION-1:0] hit;
    logic [N_REGION:0]   claimed;

    // Split the address and raise one raw hit per region
    always_comb begin
        page        = addr[ADDR_W-1 -: PAGE_W];
        off         = addr[OFF_W-1:0];
        ee_sel_page = has_ext ? ee_page : EE_FIX;
        hit           = '0;
        hit[IDX_REG]  = (page == reg_page) && (off < REG_LIM);
        hit[IDX_RAM]  = (page == ram_page) && (off < RAM_LIM);
        hit[IDX_BOOT] = ctl.boot_rom_en && (addr >= BOOT_LO) && (addr <= BOOT_HI);
        hit[IDX_EE]   = ee_en && (page == ee_sel_page) && (off >= EE_LO);
        hit[IDX_VEC]  = !has_ext && (addr >= VEC_LO);
        hit[IDX_EXT]  = has_ext;
    end

    assign claimed[0] = 1'b0;

    // Priority chain: a region wins only if no lower index hit
    for (genvar i = 0; i < N_REGION; i++) begin : g_prio
        assign claimed[i+1] = claimed[i] | hit[i];
        assign sel[i]       = hit[i] & ~claimed[i];
    end
endmodule

// File: rtl/addr_map_decoder.sv
// Top of the remappable memory map decoder. Ties the mode latch, the
// windowed mapping register and the region decoder together.
// Mapping register layout: [2*PAGE_W-1:PAGE_W] RAM page, [PAGE_W-1:0]
// register page.
module addr_map_decoder
    import addr_map_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int PAGE_W       = 4,
    parameter int RAM_BYTES    = 1024,
    parameter int REG_BYTES    = 96,
    parameter int EE_BYTES     = 512,
    parameter int BOOT_BASE    = 'hBF00,
    parameter int BOOT_BYTES   = 256,
    parameter int VEC_BASE     = 'hFFC0,
    parameter int WIN_CYCLES   = 64,
    parameter int RAM_RST_PAGE = 0,
    parameter int REG_RST_PAGE = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_pins,
    input  logic                bus_tick,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                map_wr,
    input  logic [2*PAGE_W-1:0] map_wdata,
    input  logic [PAGE_W-1:0]   ee_page,
    input  logic                ee_en,
    output logic [N_REGION-1:0] region_sel,
    output logic                boot_rom_en,
    output logic                special_mode,
    output logic                mode_a,
    output logic                ext_bus
);
    localparam int MAP_W = 2 * PAGE_W;
    localparam logic [MAP_W-1:0] MAP_RST = {PAGE_W'(RAM_RST_PAGE), PAGE_W'(REG_RST_PAGE)};

    mode_ctl_t        ctl;
    logic             has_ext;
    logic [MAP_W-1:0] map_q;

    addr_map_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pins (mode_pins),
        .ctl       (ctl),
        .has_ext   (has_ext)
    );

    addr_map_window_reg #(
        .DATA_W     (MAP_W),
        .WIN_CYCLES (WIN_CYCLES),
        .RESET_VAL  (MAP_RST)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_tick (bus_tick),
        .special  (ctl.special),
        .wr       (map_wr),
        .wdata    (map_wdata),
        .map_q    (map_q)
    );

    addr_map_region_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .RAM_BYTES  (RAM_BYTES),
        .REG_BYTES  (REG_BYTES),
        .EE_BYTES   (EE_BYTES),
        .BOOT_BASE  (BOOT_BASE),
        .BOOT_BYTES (BOOT_BYTES),
        .VEC_BASE   (VEC_BASE)
    ) u_dec (
        .addr     (addr),
        .ram_page (map_q[MAP_W-1:PAGE_W]),
        .reg_page (map_q[PAGE_W-1:0]),
        .ee_page  (ee_page),
        .ee_en    (ee_en),
        .ctl      (ctl),
        .has_ext  (has_ext),
        .sel      (region_sel)
    );

    // Expose the latched control bits
    always_comb begin
        boot_rom_en  = ctl.boot_rom_en;
        special_mode = ctl.special;
        mode_a       = ctl.mode_a;
        ext_bus      = has_ext;
    end
endmodule

// File: rtl/addr_map_decoder_chk.sv
// Property checker for addr_map_decoder, attached with bind. Keeps its
// own bus-tick counter to judge the write window.
module addr_map_decoder_chk #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 4,
    parameter int REG_BYTES  = 96,
    parameter int WIN_CYCLES = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_tick,
    input logic [ADDR_W-1:0]   addr,
    input logic [5:0]          region_sel,
    input logic                boot_rom_en,
    input logic                special_mode,
    input logic                mode_a,
    input logic                ext_bus,
    input logic [2*PAGE_W-1:0] map_q
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] WIN_L = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] win_cnt;

    // Independent count of bus ticks since reset
    always_ff @(posedge clk) begin
        if (!rst_n) win_cnt <= '0;
        else if (bus_tick && win_cnt != WIN_L) win_cnt <= win_cnt + 1'b1;
    end

    // R12
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));

    // R12
    ext_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bus |-> ($countones(region_sel) == 1));

    // R11
    no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[5] |-> ext_bus);

    // R7
    boot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[2] |-> boot_rom_en);

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable({boot_rom_en, special_mode, mode_a}));

    // R3
    map_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && win_cnt == WIN_L) |=> $stable(map_q));

    // R5
    reg_over_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[1] |-> !((addr[ADDR_W-1 -: PAGE_W] == map_q[PAGE_W-1:0])
                            && (addr[ADDR_W-PAGE_W-1:0] < (ADDR_W-PAGE_W)'(REG_BYTES))));
endmodule

bind addr_map_decoder addr_map_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .REG_BYTES  (REG_BYTES),
    .WIN_CYCLES (WIN_CYCLES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_tick     (bus_tick),
    .addr         (addr),
    .region_sel   (region_sel),
    .boot_rom_en  (boot_rom_en),
    .special_mode (special_mode),
    .mode_a       (mode_a),
    .ext_bus      (ext_bus),
    .map_q        (map_q)
);

// File: tb/addr_map_decoder_tb.sv
module addr_map_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b10;
    logic        bus_tick = 1'b0;
    logic [15:0] addr = '0;
    logic        map_wr = 1'b0;
    logic [7:0]  map_wdata = '0;
    logic [3:0]  ee_page = '0;
    logic        ee_en = 1'b0;
    logic [5:0]  region_sel;
    logic        boot_rom_en, special_mode, mode_a, ext_bus;

    always #4 clk = ~clk;

    addr_map_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .bus_tick(bus_tick),
        .addr(addr), .map_wr(map_wr), .map_wdata(map_wdata), .ee_page(ee_page),
        .ee_en(ee_en), .region_sel(region_sel), .boot_rom_en(boot_rom_en),
        .special_mode(special_mode), .mode_a(mode_a), .ext_bus(ext_bus)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference state
    int m_mode, m_ram, m_reg, m_cnt;
    bit m_used;

    int probes[24] = '{'h0000, 'h03FF, 'h0400, 'h1000, 'h105F, 'h1060,
                       'h13FF, 'h1400, 'h2000, 'h23FF, 'h2400, 'h3000,
                       'h305F, 'h3060, 'hBF00, 'hBFFF, 'hBEFF, 'hBE00,
                       'hFE00, 'hFFBF, 'hFFC0, 'hFFFF, 'h8000, 'hFDFF};

    function automatic logic [5:0] ref_sel(int a, bit een, int eeb);
        bit ext = (m_mode == 1) || (m_mode == 3);
        int eb  = ext ? eeb * 'h1000 : 'hF000;
        if (a >= m_reg * 'h1000 && a < m_reg * 'h1000 + 96) return 6'b000001;
        if (a >= m_ram * 'h1000 && a < m_ram * 'h1000 + 1024) return 6'b000010;
        if (m_mode == 0 && a >= 'hBF00 && a <= 'hBFFF) return 6'b000100;
        if (een && a >= eb + 'hE00 && a <= eb + 'hFFF) return 6'b001000;
        if (!ext && a >= 'hFFC0) return 6'b010000;
        if (ext) return 6'b100000;
        return 6'b000000;
    endfunction

    function automatic logic [3:0] ref_ctl();
        return {m_mode == 0, m_mode < 2, m_mode[0], m_mode[0]};
    endfunction

    // One bus clock: drive, compare, advance the reference
    task automatic cyc(int a, bit wr, logic [7:0] wd, bit tk);
        logic [5:0] es;
        logic [3:0] ec;
        @(negedge clk);
        addr = a[15:0]; map_wr = wr; map_wdata = wd; bus_tick = tk;
        #2;
        es = ref_sel(a, ee_en, int'(ee_page));
        ec = ref_ctl();
        n_chk++;
        if (region_sel !== es || {boot_rom_en, special_mode, mode_a, ext_bus} !== ec) begin
            n_fail++;
            $display("FAIL %s addr=%h sel=%b exp=%b ctl=%b exp=%b", cur_req, a[15:0],
                     region_sel, es, {boot_rom_en, special_mode, mode_a, ext_bus}, ec);
        end
        if (wr && ((m_mode < 2) || (m_cnt < 64 && !m_used))) begin
            m_ram = int'(wd[7:4]); m_reg = int'(wd[3:0]); m_used = 1;
        end
        if (tk && m_cnt < 64) m_cnt++;
        @(posedge clk);
    endtask

    task automatic do_reset(logic [1:0] p);
        @(negedge clk);
        rst_n = 1'b0; mode_pins = p; map_wr = 0; bus_tick = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mode_pins = ~p;  // pins move after reset; latch must hold (R6)
        m_mode = int'(p); m_ram = 0; m_reg = 1; m_cnt = 0; m_used = 0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 24; i++) cyc(probes[i], 0, 8'h00, 0);
    endtask

    task automatic idle(int n, bit tk);
        for (int i = 0; i < n; i++) cyc('h8000, 0, 8'h00, tk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 R6 R9 R10: single-chip reset map, EEPROM on and off
        cur_req = "R1"; do_reset(2'b10);
        ee_en = 1; ee_page = 4'h3; sweep();
        cur_req = "R10"; ee_en = 0; sweep();
        cur_req = "R9"; ee_en = 1; cyc('hFE00, 0, 0, 0); cyc('hFFFF, 0, 0, 0);

        // R2 R3: relocate within window, second write ignored
        cur_req = "R2"; cyc('h8000, 1, 8'h23, 1); sweep();
        cur_req = "R3"; cyc('h8000, 1, 8'h45, 1); cyc('h4000, 0, 0, 0); cyc('h5000, 0, 0, 0); sweep();

        // R3: write on the 64th tick slot is taken
        do_reset(2'b10); idle(63, 1);
        cyc('h8000, 1, 8'h23, 1); sweep();
        // R3: write after 64 ticks is dropped
        do_reset(2'b10); idle(64, 1);
        cyc('h8000, 1, 8'h23, 1); sweep();
        // R3: window counts ticks, not clocks
        do_reset(2'b10);
        for (int i = 0; i < 100; i++) cyc('h8000, 0, 0, i[0]);
        cyc('h8000, 1, 8'h23, 1); sweep();

        // R5 R8 R11: expanded, overlapping windows, movable EEPROM
        cur_req = "R5"; do_reset(2'b11);
        cyc('h8000, 1, 8'h33, 1); sweep();
        cur_req = "R8"; ee_page = 4'hB; ee_en = 1; sweep();
        cyc('hBE00, 0, 0, 0); cyc('hBFFF, 0, 0, 0);
        cur_req = "R11"; ee_en = 0; sweep();

        // R4 R7: bootstrap, late and repeated writes accepted
        cur_req = "R7"; do_reset(2'b00); ee_en = 1; ee_page = 4'h2; sweep();
        cur_req = "R4"; idle(80, 1);
        cyc('h8000, 1, 8'h23, 1); sweep();
        cyc('h8000, 1, 8'h77, 1); sweep();
        cur_req = "R10"; ee_en = 0; sweep();

        // R6 R12: test mode, no boot ROM, external fills gaps
        cur_req = "R12"; do_reset(2'b01); ee_en = 1; ee_page = 4'hF; sweep();
        cur_req = "R4"; idle(70, 1); cyc('h8000, 1, 8'h11, 0); sweep();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule